// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences the operand transfers of one DMA channel over a simple synchronous bus. It has two modes. In dual-address mode every operand takes two bus cycles: a read from the source address into an internal holding register, then a write of that value to the destination address. In single-address mode every operand takes exactly one bus cycle and only memory is addressed. A requesting device beside the bus supplies or takes the data, and a handshake-select bit decides whether that cycle is a source read or a destination write.

Software-side logic presents the configuration and pulses `start`. The channel then loads its address pointers and byte count and waits for requests. Requests come either from the external `dreq` pin or, in dual-address mode only, from an internal auto-start. It gains the bus through a request/grant pair and runs each cycle until the target acknowledges. After every operand the pointers advance and the count drops by the operand size. The transfer ends when the count is used up or a bus error occurs. In burst mode the channel keeps the bus while requests persist. In cycle-steal mode it gives the bus back after every operand.

The bus-cycle port is a valid/ready pair: `bus_cyc` is valid and `bus_ack` is ready. While `bus_cyc` is high and neither `bus_ack` nor `bus_err` has been seen, address, direction, function code, size and write data stay unchanged. A target that withholds `bus_ack` stalls the channel for as long as it likes.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset, `bus_req`, `bus_cyc`, `dack`, `ddone`, `busy`, `done` and `err` are all 0.
- R2: In dual-address mode (`cfg_single`=0), each operand is a read cycle (`bus_we`=0) at the source address with the source function code, followed by a write cycle (`bus_we`=1) at the destination address with the destination function code. The write data equals the `bus_rdata` captured when the read was acknowledged.
- R3: In single-address mode, each operand is one cycle. With `cfg_hs_src`=1 it is a read (`bus_we`=0) at the source address and source function code. With `cfg_hs_src`=0 it is a write (`bus_we`=1) at the destination address and destination function code.
- R4: In single-address mode a transfer waits for `dreq` even when `cfg_ext_req`=0. The internal auto-start is ignored, and `bus_req` stays 0 until `dreq` is seen.
- R5: When external requests are in use (single-address mode, or `cfg_ext_req`=1), `dack` is high for exactly the bus cycles on the handshake side: every single-address cycle, or in dual mode the read when `cfg_hs_src`=1 and the write when `cfg_hs_src`=0. `ddone` equals `dack` on the final operand and is 0 otherwise.
- R6: After each operand, the source and destination pointers each advance by the operand size when their increment bit is set, and hold when it is clear. The size encoding of `cfg_size` is 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. `bus_size` carries the latched code.
- R7: After each operand the count drops by the operand size. When the remaining count is no larger than the size, that operand is the last. The channel then returns to idle with `busy`=0 and `done`=1.
- R8: A start with `cfg_count`=0 causes no bus cycle, and `done` is 1 in the cycle after the start.
- R9: In cycle-steal mode (`cfg_burst`=0) with external requests, each rising edge of `dreq` yields exactly one operand. An edge seen while an operand runs is remembered. `bus_req` drops after each operand.
- R10: In burst mode, `dreq` is sampled as a level when each operand completes. If it is high, the next operand starts at once without dropping `bus_req`. If it is low, the bus is released until `dreq` returns.
- R11: `bus_req` stays high from the request until grant. A bus cycle holds its address and direction stable until `bus_ack` or `bus_err`.
- R12: `bus_err` during a bus cycle aborts the transfer. In the next cycle `busy`=0 and `err`=1, and `done` stays 0.
- R13: `start` while `busy`=1 is ignored. The running transfer completes with its original count and addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer with the present configuration (ignored while busy) |
| cfg_src_addr | input | AW | Initial source address |
| cfg_dst_addr | input | AW | Initial destination address |
| cfg_src_fc | input | FCW | Source function code |
| cfg_dst_fc | input | FCW | Destination function code |
| cfg_size | input | 2 | Operand size code (0: 1 B, 1: 2 B, 2/3: 4 B) |
| cfg_count | input | CW | Byte count |
| cfg_single | input | 1 | 1 = single-address mode, 0 = dual-address mode |
| cfg_hs_src | input | 1 | 1 = handshake on source (read), 0 = on destination (write) |
| cfg_burst | input | 1 | 1 = burst, 0 = cycle steal |
| cfg_ext_req | input | 1 | 1 = external requests in dual mode (forced in single mode) |
| cfg_src_inc | input | 1 | Advance source pointer per operand |
| cfg_dst_inc | input | 1 | Advance destination pointer per operand |
| dreq | input | 1 | External transfer request |
| dack | output | 1 | Handshake acknowledge to the requesting device |
| ddone | output | 1 | Final-operand marker alongside `dack` |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| bus_cyc | output | 1 | Bus cycle valid |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | output | AW | Cycle address |
| bus_fc | output | FCW | Cycle function code |
| bus_size | output | 2 | Cycle operand size code |
| bus_wdata | output | DW | Write data (holding register) |
| bus_rdata | input | DW | Read data from the target |
| bus_ack | input | 1 | Target acknowledge (cycle ready) |
| bus_err | input | 1 | Target bus error |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer ended normally |
| err | output | 1 | Last transfer ended by bus error |

## Verification
The assertions take the bus side to be well behaved. `bus_gnt` is only given while `bus_req` is high. `bus_ack` and `bus_err` arrive only during a valid cycle, and never both at once. A cycle-steal request is a clean pulse rather than a glitch inside one clock. The bench's responder grants only after it has seen `bus_req` and keeps the grant while the request lasts. It raises an acknowledge or a single armed error only while `bus_cyc` is high, and always inserts a quiet cycle after each response. Its `dreq` stimulus is driven on the falling edge as one-cycle pulses or held levels.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WREQ = 3'd1,
    ST_ARB  = 3'd2,
    ST_CYA  = 3'd3,
    ST_CYB  = 3'd4
  } seq_state_t;

  function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_to_bytes = 3'd1;
      2'd1:    size_to_bytes = 3'd2;
      default: size_to_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_req_qual.sv
module dma_req_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq,
  input  logic clr,
  input  logic consume,
  input  logic ext,
  input  logic burst,
  output logic req_ok
);
  logic dreq_q;
  logic pend_q;
  logic rise;

  assign rise = dreq & ~dreq_q;

  always_comb begin
    if (!ext)       req_ok = 1'b1;
    else if (burst) req_ok = dreq;
    else            req_ok = pend_q | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreq_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      dreq_q <= dreq;
      if (clr || consume) pend_q <= 1'b0;
      else                pend_q <= pend_q | rise;
    end
  end
endmodule

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] src_init,
  input  logic [AW-1:0] dst_init,
  input  logic [1:0]    inc_en,
  input  logic [CW-1:0] cnt_init,
  input  logic [2:0]    nbytes,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic          last
);
  localparam int NPTR = 2;

  logic [AW-1:0] init_v [NPTR];
  logic [AW-1:0] ptr_q  [NPTR];
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] step_w;

  assign init_v[0] = src_init;
  assign init_v[1] = dst_init;
  assign step_w    = CW'(nbytes);

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ptr_q[g] <= '0;
      else if (load)              ptr_q[g] <= init_v[g];
      else if (step && inc_en[g]) ptr_q[g] <= ptr_q[g] + AW'(nbytes);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= cnt_init;
    else if (step) cnt_q <= last ? '0 : cnt_q - step_w;
  end

  assign src  = ptr_q[0];
  assign dst  = ptr_q[1];
  assign cnt  = cnt_q;
  assign last = (cnt_q <= step_w);
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int FCW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           go_zero,
  input  logic           req_ok,
  input  logic           bus_gnt,
  input  logic           bus_ack,
  input  logic           bus_err,
  input  logic           single,
  input  logic           hs_src,
  input  logic           burst,
  input  logic           ext,
  input  logic           last,
  input  logic [DW-1:0]  bus_rdata,
  input  logic [AW-1:0]  src,
  input  logic [AW-1:0]  dst,
  input  logic [FCW-1:0] src_fc,
  input  logic [FCW-1:0] dst_fc,
  output logic           step,
  output logic           consume,
  output logic           busy,
  output logic           bus_req,
  output logic           bus_cyc,
  output logic           bus_we,
  output logic [AW-1:0]  bus_addr,
  output logic [FCW-1:0] bus_fc,
  output logic [DW-1:0]  bus_wdata,
  output logic           dack,
  output logic           ddone,
  output logic           done,
  output logic           err
);
  seq_state_t st_q, st_d;
  logic [DW-1:0] hold_q;
  logic done_q, err_q;
  logic op_end;
  logic dst_side;

  // operand ends on the ack of its last cycle
  assign op_end = bus_ack && !bus_err &&
                  ((st_q == ST_CYA && single) || st_q == ST_CYB);

  always_comb begin
    st_d    = st_q;
    consume = 1'b0;
    case (st_q)
      ST_IDLE: if (go && !go_zero) st_d = ST_WREQ;
      ST_WREQ: if (req_ok) begin
                 st_d    = ST_ARB;
                 consume = 1'b1;
               end
      ST_ARB:  if (bus_gnt) st_d = ST_CYA;
      ST_CYA:  if (bus_err) st_d = ST_IDLE;
               else if (bus_ack) st_d = single ? ST_WREQ : ST_CYB;
      ST_CYB:  if (bus_err) st_d = ST_IDLE;
               else if (bus_ack) st_d = ST_WREQ;
      default: st_d = ST_IDLE;
    endcase
    if (op_end) begin
      if (last) st_d = ST_IDLE;
      else if (burst && req_ok) begin
        st_d    = ST_CYA;
        consume = 1'b1;
      end else st_d = ST_WREQ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hold_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_CYA && !single && bus_ack && !bus_err) hold_q <= bus_rdata;
      if (go) begin
        done_q <= go_zero;
        err_q  <= 1'b0;
      end else begin
        if (op_end && last) done_q <= 1'b1;
        if (bus_cyc && bus_err) err_q <= 1'b1;
      end
    end
  end

  assign step = op_end;

  // which side the present cycle addresses
  assign dst_side  = (st_q == ST_CYB) || (st_q == ST_CYA && single && !hs_src);
  assign busy      = (st_q != ST_IDLE);
  assign bus_cyc   = (st_q == ST_CYA) || (st_q == ST_CYB);
  assign bus_req   = bus_cyc || (st_q == ST_ARB);
  assign bus_we    = bus_cyc && dst_side;
  assign bus_addr  = dst_side ? dst : src;
  assign bus_fc    = dst_side ? dst_fc : src_fc;
  assign bus_wdata = hold_q;
  assign dack      = ext && bus_cyc && (single || (dst_side != hs_src));
  assign ddone     = dack && last;
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 24,
  parameter int FCW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  cfg_src_addr,
  input  logic [AW-1:0]  cfg_dst_addr,
  input  logic [FCW-1:0] cfg_src_fc,
  input  logic [FCW-1:0] cfg_dst_fc,
  input  logic [1:0]     cfg_size,
  input  logic [CW-1:0]  cfg_count,
  input  logic           cfg_single,
  input  logic           cfg_hs_src,
  input  logic           cfg_burst,
  input  logic           cfg_ext_req,
  input  logic           cfg_src_inc,
  input  logic           cfg_dst_inc,
  input  logic           dreq,
  output logic           dack,
  output logic           ddone,
  output logic           bus_req,
  input  logic           bus_gnt,
  output logic           bus_cyc,
  output logic           bus_we,
  output logic [AW-1:0]  bus_addr,
  output logic [FCW-1:0] bus_fc,
  output logic [1:0]     bus_size,
  output logic [DW-1:0]  bus_wdata,
  input  logic [DW-1:0]  bus_rdata,
  input  logic           bus_ack,
  input  logic           bus_err,
  output logic           busy,
  output logic           done,
  output logic           err
);
  logic           go, go_zero;
  logic           single_q, hs_q, burst_q, ext_q;
  logic [1:0]     size_q, inc_q;
  logic [FCW-1:0] sfc_q, dfc_q;
  logic [2:0]     nbytes;
  logic           req_ok, consume, step, last;
  logic [AW-1:0]  src, dst;
  logic [CW-1:0]  cnt;

  assign go      = start && !busy;
  assign go_zero = (cfg_count == '0);
  assign nbytes  = size_to_bytes(size_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_q <= 1'b0;
      hs_q     <= 1'b0;
      burst_q  <= 1'b0;
      ext_q    <= 1'b0;
      size_q   <= '0;
      inc_q    <= '0;
      sfc_q    <= '0;
      dfc_q    <= '0;
    end else if (go) begin
      single_q <= cfg_single;
      hs_q     <= cfg_hs_src;
      burst_q  <= cfg_burst;
      ext_q    <= cfg_single | cfg_ext_req;
      size_q   <= cfg_size;
      inc_q    <= {cfg_dst_inc, cfg_src_inc};
      sfc_q    <= cfg_src_fc;
      dfc_q    <= cfg_dst_fc;
    end
  end

  dma_req_qual u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .dreq    (dreq),
    .clr     (go),
    .consume (consume),
    .ext     (ext_q),
    .burst   (burst_q),
    .req_ok  (req_ok)
  );

  dma_ptr_unit #(.AW(AW), .CW(CW)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (go),
    .step     (step),
    .src_init (cfg_src_addr),
    .dst_init (cfg_dst_addr),
    .inc_en   (inc_q),
    .cnt_init (cfg_count),
    .nbytes   (nbytes),
    .src      (src),
    .dst      (dst),
    .cnt      (cnt),
    .last     (last)
  );

  dma_seq_ctrl #(.AW(AW), .DW(DW), .FCW(FCW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .go_zero   (go_zero),
    .req_ok    (req_ok),
    .bus_gnt   (bus_gnt),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .single    (single_q),
    .hs_src    (hs_q),
    .burst     (burst_q),
    .ext       (ext_q),
    .last      (last),
    .bus_rdata (bus_rdata),
    .src       (src),
    .dst       (dst),
    .src_fc    (sfc_q),
    .dst_fc    (dfc_q),
    .step      (step),
    .consume   (consume),
    .busy      (busy),
    .bus_req   (bus_req),
    .bus_cyc   (bus_cyc),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_fc    (bus_fc),
    .bus_wdata (bus_wdata),
    .dack      (dack),
    .ddone     (ddone),
    .done      (done),
    .err       (err)
  );

  assign bus_size = size_q;

  logic unused_cnt;
  assign unused_cnt = ^cnt;
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_cyc,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ack,
  input logic          bus_err,
  input logic          dack,
  input logic          ddone,
  input logic          busy,
  input logic          done,
  input logic          err
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req && !dack && !ddone); // R1

  AST_REQ_UNTIL_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt && !bus_cyc |=> bus_req); // R11

  AST_CYC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && !bus_ack && !bus_err |=> bus_cyc && $stable(bus_addr) && $stable(bus_we)); // R11

  AST_CYC_OWNS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc |-> bus_req); // R11

  AST_DONE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ddone |-> dack); // R5

  AST_ACK_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> bus_cyc); // R5

  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && bus_err |=> !busy && err && !done); // R12
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_gnt  (bus_gnt),
  .bus_cyc  (bus_cyc),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_ack  (bus_ack),
  .bus_err  (bus_err),
  .dack     (dack),
  .ddone    (ddone),
  .busy     (busy),
  .done     (done),
  .err      (err)
);

// File: tb/dma_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module dma_xfer_seq_tb_top;
  localparam int AW = 32, DW = 32, CW = 24, FCW = 3;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic start = 0;
  logic [AW-1:0] cfg_src_addr = 0, cfg_dst_addr = 0;
  logic [FCW-1:0] cfg_src_fc = 0, cfg_dst_fc = 0;
  logic [1:0] cfg_size = 0;
  logic [CW-1:0] cfg_count = 0;
  logic cfg_single = 0, cfg_hs_src = 0, cfg_burst = 0, cfg_ext_req = 0;
  logic cfg_src_inc = 0, cfg_dst_inc = 0, dreq = 0;
  logic dack, ddone, bus_req, bus_gnt = 0, bus_cyc, bus_we;
  logic [AW-1:0] bus_addr;
  logic [FCW-1:0] bus_fc;
  logic [1:0] bus_size;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic bus_ack = 0, bus_err = 0, busy, done, err;

  assign bus_rdata = {~bus_addr[15:0], bus_addr[15:0]};

  dma_xfer_seq #(.AW(AW), .DW(DW), .CW(CW), .FCW(FCW)) dut_i (.*);

  int vectors = 0, miscompares = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_st = 0;              // 0 idle,1 wait req,2 arbitrate,3 first cycle,4 second cycle
  longint m_src, m_dst, m_cnt;
  int m_nb, m_size, m_sfc, m_dfc;
  bit m_single, m_hs, m_burst, m_ext, m_sinc, m_dinc;
  bit m_pend, m_dq, m_done, m_err;
  longint m_hold;

  function automatic longint rd_of(longint a);
    return {~a[15:0], a[15:0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_pend = 0; m_dq = 0; m_done = 0; m_err = 0; m_hold = 0;
      m_src = 0; m_dst = 0; m_cnt = 0; m_size = 0; m_nb = 1;
      m_single = 0; m_hs = 0; m_burst = 0; m_ext = 0; m_sinc = 0; m_dinc = 0;
      m_sfc = 0; m_dfc = 0;
    end else begin
      bit rise, rok, take, go, fin, lastop;
      int nst;
      go = start && (m_st == 0);
      rise = dreq && !m_dq;
      rok = !m_ext ? 1 : (m_burst ? dreq : (m_pend || rise));
      lastop = (m_cnt <= m_nb);
      take = 0; fin = 0; nst = m_st;
      if (m_st == 0) begin
        if (go) begin
          m_single = cfg_single; m_hs = cfg_hs_src; m_burst = cfg_burst;
          m_ext = cfg_single || cfg_ext_req; m_size = cfg_size;
          m_nb = (cfg_size == 0) ? 1 : (cfg_size == 1) ? 2 : 4;
          m_sinc = cfg_src_inc; m_dinc = cfg_dst_inc;
          m_sfc = cfg_src_fc; m_dfc = cfg_dst_fc;
          m_src = cfg_src_addr; m_dst = cfg_dst_addr; m_cnt = cfg_count;
          m_done = (cfg_count == 0); m_err = 0;
          nst = (cfg_count == 0) ? 0 : 1;
        end
      end else if (m_st == 1) begin
        if (rok) begin nst = 2; take = 1; end
      end else if (m_st == 2) begin
        if (bus_gnt) nst = 3;
      end else begin
        if (bus_err) begin nst = 0; m_err = 1; end
        else if (bus_ack) begin
          if (m_st == 3 && !m_single) begin m_hold = rd_of(m_src); nst = 4; end
          else fin = 1;
        end
      end
      if (fin) begin
        if (m_sinc) m_src = (m_src + m_nb) & 64'hFFFF_FFFF;
        if (m_dinc) m_dst = (m_dst + m_nb) & 64'hFFFF_FFFF;
        m_cnt = lastop ? 0 : m_cnt - m_nb;
        if (lastop) begin nst = 0; m_done = 1; end
        else if (m_burst && rok) begin nst = 3; take = 1; end
        else nst = 1;
      end
      if (go || take) m_pend = 0; else m_pend = m_pend || rise;
      m_dq = dreq;
      m_st = nst;
    end
  end

  // per-cycle comparison of every output against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit cyc, dside, edack;
      cyc = (m_st >= 3);
      dside = (m_st == 4) || (m_st == 3 && m_single && !m_hs);
      edack = m_ext && cyc && (m_single || (dside != m_hs));
      chk("R7 busy", busy, m_st != 0);
      chk("R7 done", done, m_done);
      chk("R12 err", err, m_err);
      chk("R11 bus_req", bus_req, m_st >= 2);
      chk("R11 bus_cyc", bus_cyc, cyc);
      chk("R5 dack", dack, edack);
      chk("R5 ddone", ddone, edack && (m_cnt <= m_nb));
      if (cyc) begin
        chk(m_single ? "R3 bus_we" : "R2 bus_we", bus_we, dside);
        chk("R6 bus_addr", bus_addr, dside ? m_dst : m_src);
        chk(m_single ? "R3 bus_fc" : "R2 bus_fc", bus_fc, dside ? m_dfc : m_sfc);
        chk("R6 bus_size", bus_size, m_size);
        if (m_st == 4) chk("R2 bus_wdata", bus_wdata, m_hold);
      end
    end
  end

  // ---------------- bus responder ----------------
  int gnt_lat = 1, ack_lat = 1, gcnt = 0, acnt = 0;
  bit err_arm = 0;
  always @(negedge clk) begin
    if (bus_req) begin gcnt++; bus_gnt <= (gcnt > gnt_lat); end
    else begin gcnt = 0; bus_gnt <= 0; end
    if (bus_ack || bus_err) begin bus_ack <= 0; bus_err <= 0; acnt = 0; end
    else if (bus_cyc) begin
      acnt++;
      if (acnt > ack_lat) begin
        if (err_arm) begin bus_err <= 1; err_arm = 0; end
        else bus_ack <= 1;
      end
    end else acnt = 0;
  end

  // observers
  int acks = 0, req_drops = 0;
  logic [AW-1:0] last_waddr;
  bit req_d = 0;
  always @(posedge clk) begin
    if (bus_cyc && bus_ack && !bus_err) begin
      acks++;
      if (bus_we) last_waddr = bus_addr;
    end
    if (req_d && !bus_req && busy) req_drops++;
    req_d = bus_req;
  end

  // ---------------- stimulus ----------------
  task automatic cfg(input bit single, hs, burst, ext, sinc, dinc, input int size,
                     input int count, input longint sa, da);
    cfg_single = single; cfg_hs_src = hs; cfg_burst = burst; cfg_ext_req = ext;
    cfg_src_inc = sinc; cfg_dst_inc = dinc; cfg_size = size[1:0];
    cfg_count = count[CW-1:0]; cfg_src_addr = sa[AW-1:0]; cfg_dst_addr = da[AW-1:0];
    cfg_src_fc = 3'd5; cfg_dst_fc = 3'd1;
  endtask

  task automatic go();
    @(negedge clk); acks = 0; req_drops = 0; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic pulse();
    @(negedge clk); dreq = 1;
    @(negedge clk); dreq = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 bus_req reset", bus_req, 0);
    chk("R1 busy reset", busy, 0);
    chk("R1 done/err reset", {done, err, dack, ddone, bus_cyc}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // dual, internal, cycle steal, long operands
    cfg(0, 1, 0, 0, 1, 1, 2, 12, 'h1000, 'h2000);
    go(); wait_idle();
    chk("R2 dual cycles", acks, 6);
    chk("R7 done dual", done, 1);

    // dual burst bytes, destination fixed
    gnt_lat = 2; ack_lat = 0;
    cfg(0, 0, 1, 0, 1, 0, 0, 3, 'h3001, 'h4003);
    go(); wait_idle();
    chk("R6 fixed dst", last_waddr, 'h4003);
    chk("R10 no bus drop internal burst", req_drops, 0);

    // odd count clamp, dual long
    ack_lat = 2;
    cfg(0, 1, 0, 1, 1, 1, 3, 5, 'h10, 'h20);
    go(); pulse(); repeat (20) @(negedge clk); pulse(); wait_idle();
    chk("R7 clamp ops", acks, 4);

    // zero count
    cfg(0, 0, 0, 0, 1, 1, 0, 0, 'h0, 'h0);
    @(negedge clk); acks = 0; start = 1;
    @(negedge clk); start = 0;
    chk("R8 done after zero start", done, 1);
    chk("R8 busy zero", busy, 0);
    repeat (3) @(negedge clk);
    chk("R8 no cycle", acks, 0);

    // single read, internal selected but must wait for dreq, cycle steal
    ack_lat = 1; gnt_lat = 1;
    cfg(1, 1, 0, 0, 1, 0, 1, 6, 'h5000, 'h6000);
    go(); repeat (10) @(negedge clk);
    chk("R4 no bus_req without dreq", bus_req, 0);
    pulse(); repeat (15) @(negedge clk);
    chk("R9 one op per pulse", acks, 1);
    chk("R9 still busy", busy, 1);
    pulse(); repeat (15) @(negedge clk);
    pulse(); wait_idle();
    chk("R3 single read ops", acks, 3);
    chk("R9 bus dropped", req_drops, 2);

    // single write burst, level dreq
    cfg(1, 0, 1, 1, 0, 1, 1, 8, 'h7000, 'h8000);
    go(); @(negedge clk); dreq = 1;
    repeat (6) @(negedge clk); dreq = 0;
    repeat (25) @(negedge clk);
    chk("R10 paused busy", busy, 1);
    @(negedge clk); dreq = 1; wait_idle(); dreq = 0;
    chk("R3 single write ops", acks, 4);
    chk("R10 done", done, 1);

    // bus error abort, with start while busy ignored
    cfg(0, 1, 0, 0, 1, 1, 2, 16, 'h9000, 'hA000);
    go(); repeat (4) @(negedge clk);
    cfg(0, 1, 0, 0, 1, 1, 2, 4, 'h0, 'h0);
    start = 1; @(negedge clk); start = 0;
    chk("R13 still busy", busy, 1);
    repeat (10) @(negedge clk); err_arm = 1; wait_idle();
    chk("R12 err set", err, 1);
    chk("R12 done clear", done, 0);
    chk("R13 original count kept", acks > 2, 1);

    // clean run after error clears err
    cfg(0, 0, 0, 1, 1, 1, 1, 4, 'hB000, 'hC000);
    go(); pulse(); repeat (20) @(negedge clk); pulse(); wait_idle();
    chk("R5 ext dual ops", acks, 4);
    chk("R12 err cleared", err, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule